// File: doc/BRIEF.md
# Power-Management Event and SCI Controller

This block is a small register file for power-management events, reached through a simple address/data request port. It keeps a 16-bit event status register, a 16-bit event enable register, a 16-bit control register, an 8-bit general-purpose-event (GPE) status and enable pair, and a free-running timer that can only be read. From these it drives a level-sensitive system control interrupt (`sci`): the masked status of four event sources, or of the hotplug bit of the GPE byte. Event sources set status bits through pulse inputs. Software clears status bits by writing ones to them.

A separate one-byte command port switches the SCI-enable bit of the control register. One code value turns it on and another turns it off. When a configuration input permits, any command byte also raises a one-cycle SMI pulse. The 64-byte register window is relocatable: its base comes from a configuration word with the low six bits ignored. The window decodes only while a map-enable input is high.

Requests carry no ready signal, because the block never stalls. A request is consumed in every cycle where `req_valid` is high. Every read request produces `rsp_valid` exactly one cycle later, and the consumer has no way to back-pressure that response.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, the status, enable, control, GPE status and GPE enable registers read zero, and `sci` and `smi` are low.
- R2: The window covers 64 bytes at `cfg_base & 16'hFFC0`. It decodes only while `cfg_win_en` is 1. A write outside the window, or a write while decoding is off, changes nothing. A read there returns zero.
- R3: The window offsets are as follows:
  - 0x00: event status
  - 0x02: event enable
  - 0x04: control
  - 0x08: timer
  - 0x0C: GPE status (8 bits)
  - 0x0E: GPE enable (8 bits)
- R4: Other offsets read zero. Each read is answered on `rsp_valid`/`rsp_rdata` one cycle after it is taken.
- R5: Writing a 1 to an event status bit clears that bit, and writing a 0 leaves it unchanged. A high bit of `evt_set` sets the matching status bit. A set in the same cycle as a clear of the same bit wins.
- R6: `sci` is high when status AND enable is nonzero in bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC alarm). Other status bits never raise `sci`. A change is visible right after the clock edge that takes the write or the event.
- R7: `sci` is also high when GPE status bit 1 (hotplug) AND GPE enable bit 1 is set. `gpe_set` sets GPE status bits, and a written 1 clears them. Other GPE bits never raise `sci`.
- R8: Command byte 0xF1 sets control bit 0 (SCI enable). Command byte 0xF0 clears it. Any other byte leaves the control register unchanged.
- R9: Any command byte taken while `cfg_smi_en` is 1 makes `smi` high for the following cycle. With `cfg_smi_en` at 0, `smi` stays low.
- R10: The timer is a `TMR_W`-bit counter that advances every cycle. It reads zero-extended to 32 bits.
- R11: A toggle of the timer's top bit sets status bit 0 only while enable bit 0 is set. With enable bit 0 clear, such a toggle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 16 | Window base; bits 5:0 ignored |
| cfg_win_en | input | 1 | Window decode enable |
| cfg_smi_en | input | 1 | Permits SMI on command bytes |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read response data |
| evt_set | input | 16 | Per-bit event status set pulses |
| gpe_set | input | 8 | Per-bit GPE status set pulses |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command byte |
| sci | output | 1 | Level system control interrupt |
| smi | output | 1 | One-cycle SMI pulse |

## Verification
Register writes, event pulses and command bytes all land on the clock edge that takes them. The bench drives them on a falling edge and samples `sci` and register effects at the next falling edge. A read returns on the edge after it is taken, so each read task samples `rsp_rdata` one falling edge after driving. The `smi` pulse is checked high at the first falling edge after the command and low at the second. Timer steps are checked from two reads taken two cycles apart, so the expected difference is exactly 2.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned GPE_W  = 8;
  localparam int unsigned RD_W   = 32;
  localparam int unsigned OFF_W  = 6;

  localparam logic [OFF_W-1:0] OFF_STS  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN   = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_GSTS = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_GEN  = 6'h0E;

  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GBL = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_RTC = 10;
  localparam int unsigned BIT_HP  = 1;
  localparam int unsigned BIT_SCIEN = 0;

  localparam logic [REG_W-1:0] SCI_SRC_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

  localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0] CMD_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_decode.sv
module pm_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              win_en,
  output logic              hit,
  output logic [$clog2(WIN_BYTES)-1:0] offset
);
  localparam int unsigned OFS_W = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'(WIN_BYTES - 1);

  assign hit    = win_en && ((addr & WIN_MASK) == (base & WIN_MASK));
  assign offset = addr[OFS_W-1:0];
endmodule

// File: rtl/pm_free_timer.sv
module pm_free_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] count,
  output logic             msb_flip
);
  localparam logic [TMR_W-2:0] LOW_ONES = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end

  // High in the cycle whose increment changes the top bit.
  assign msb_flip = (count[TMR_W-2:0] == LOW_ONES);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == TMR_W'($past(count) + 1'b1));
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] wdata,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic             wr_gsts,
  input  logic             wr_gen,
  input  logic [REG_W-1:0] evt_set,
  input  logic [GPE_W-1:0] gpe_set,
  input  logic             tmr_flip,
  input  logic             cmd_on,
  input  logic             cmd_off,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] ctl,
  output logic [GPE_W-1:0] gsts,
  output logic [GPE_W-1:0] gen,
  output logic             sci
);
  logic [REG_W-1:0] sts_clr, sts_set;
  logic [GPE_W-1:0] gsts_clr;
  logic [REG_W-1:0] ctl_next;

  always_comb begin
    sts_clr  = wr_sts  ? wdata : '0;
    gsts_clr = wr_gsts ? wdata[GPE_W-1:0] : '0;
    sts_set  = evt_set;
    if (tmr_flip && en[BIT_TMR]) sts_set[BIT_TMR] = 1'b1;
    ctl_next = wr_ctl ? wdata : ctl;
    if (cmd_on)  ctl_next[BIT_SCIEN] = 1'b1;
    if (cmd_off) ctl_next[BIT_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts  <= '0;
      en   <= '0;
      ctl  <= '0;
      gsts <= '0;
      gen  <= '0;
    end else begin
      sts  <= (sts & ~sts_clr) | sts_set;
      gsts <= (gsts & ~gsts_clr) | gpe_set;
      ctl  <= ctl_next;
      if (wr_en)  en  <= wdata;
      if (wr_gen) gen <= wdata[GPE_W-1:0];
    end
  end

  assign sci = (|(sts & en & SCI_SRC_MASK)) || (gsts[BIT_HP] && gen[BIT_HP]);

  p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((sts & $past(evt_set)) == $past(evt_set)));
  p_sci_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on |=> ctl[BIT_SCIEN]);
  p_sci_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !ctl[BIT_SCIEN]);
  p_tmr_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flip && !en[BIT_TMR] && !evt_set[BIT_TMR] && !sts[BIT_TMR]) |=> !sts[BIT_TMR]);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W     = 24,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_base,
  input  logic        cfg_win_en,
  input  logic        cfg_smi_en,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic [15:0] evt_set,
  input  logic [7:0]  gpe_set,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_byte,
  output logic        sci,
  output logic        smi
);
  localparam int unsigned OFS_W = $clog2(WIN_BYTES);

  logic             hit;
  logic [OFS_W-1:0] ofs;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [REG_W-1:0] sts, en, ctl;
  logic [GPE_W-1:0] gsts, gen;
  logic             wr_ok;
  logic [RD_W-1:0]  rd_mux;

  pm_decode #(.ADDR_W(16), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr(req_addr), .base(cfg_base), .win_en(cfg_win_en),
    .hit(hit), .offset(ofs)
  );

  pm_free_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .count(tmr_cnt), .msb_flip(tmr_flip)
  );

  assign wr_ok = req_valid && req_write && hit;

  pm_event_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(req_wdata),
    .wr_sts (wr_ok && ofs == OFS_W'(OFF_STS)),
    .wr_en  (wr_ok && ofs == OFS_W'(OFF_EN)),
    .wr_ctl (wr_ok && ofs == OFS_W'(OFF_CTL)),
    .wr_gsts(wr_ok && ofs == OFS_W'(OFF_GSTS)),
    .wr_gen (wr_ok && ofs == OFS_W'(OFF_GEN)),
    .evt_set(evt_set), .gpe_set(gpe_set), .tmr_flip(tmr_flip),
    .cmd_on (cmd_valid && cmd_byte == CMD_SCI_ON),
    .cmd_off(cmd_valid && cmd_byte == CMD_SCI_OFF),
    .sts(sts), .en(en), .ctl(ctl), .gsts(gsts), .gen(gen), .sci(sci)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (ofs)
        OFS_W'(OFF_STS):  rd_mux = RD_W'(sts);
        OFS_W'(OFF_EN):   rd_mux = RD_W'(en);
        OFS_W'(OFF_CTL):  rd_mux = RD_W'(ctl);
        OFS_W'(OFF_TMR):  rd_mux = RD_W'(tmr_cnt);
        OFS_W'(OFF_GSTS): rd_mux = RD_W'(gsts);
        OFS_W'(OFF_GEN):  rd_mux = RD_W'(gen);
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      smi       <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      smi       <= cmd_valid && cfg_smi_en;
    end
  end

  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_smi_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cfg_smi_en) |=> smi);
  p_smi_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !smi);
endmodule

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base = 16'h1234;
  logic        cfg_win_en = 1'b1;
  logic        cfg_smi_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] evt_set = '0;
  logic [7:0]  gpe_set = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        sci, smi;

  int checks = 0, errors = 0;
  localparam logic [15:0] BASE = 16'h1200;

  always #5 clk = ~clk;

  pm_event_ctrl #(.TMR_W(8)) dut (
    .clk, .rst_n, .cfg_base, .cfg_win_en, .cfg_smi_en,
    .req_valid, .req_write, .req_addr, .req_wdata, .rsp_valid, .rsp_rdata,
    .evt_set, .gpe_set, .cmd_valid, .cmd_byte, .sci, .smi
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R4: actual rsp_valid=0 expected=1");
    end
    d = rsp_rdata;
  endtask

  task automatic pulse_evt(input logic [15:0] e, input logic [7:0] g);
    @(negedge clk);
    evt_set = e; gpe_set = g;
    @(negedge clk);
    evt_set = '0; gpe_set = '0;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 sci", {31'b0, sci}, 0);
    check("R1 smi", {31'b0, smi}, 0);
    rd(BASE + 16'h00, d); check("R1 status", d, 0);
    rd(BASE + 16'h02, d); check("R1 enable", d, 0);
    rd(BASE + 16'h04, d); check("R1 control", d, 0);
    rd(BASE + 16'h0C, d); check("R1 gpe status", d, 0);
    rd(BASE + 16'h0E, d); check("R1 gpe enable", d, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(BASE + 16'h02, 16'h0400);
    rd(BASE + 16'h02, d); check("R3 enable readback", d, 32'h0400);
    cfg_win_en = 0;
    wr(BASE + 16'h02, 16'hFFFE);
    rd(BASE + 16'h02, d); check("R2 read while unmapped", d, 0);
    cfg_win_en = 1;
    rd(BASE + 16'h02, d); check("R2 write while unmapped ignored", d, 32'h0400);
    wr(16'h1302, 16'hFFFE);
    rd(BASE + 16'h02, d); check("R2 outside write ignored", d, 32'h0400);
    rd(16'h1302, d); check("R2 outside read", d, 0);
    rd(BASE + 16'h34, d); check("R4 unmapped offset", d, 0);
    wr(BASE + 16'h02, 16'h0000);
  endtask

  task automatic t_status_sci();
    logic [31:0] d;
    pulse_evt(16'h0100, 8'h00);
    check("R6 masked source", {31'b0, sci}, 0);
    wr(BASE + 16'h02, 16'h0100);
    check("R6 power button", {31'b0, sci}, 1);
    wr(BASE + 16'h00, 16'h0000);
    check("R5 write zero no effect", {31'b0, sci}, 1);
    wr(BASE + 16'h00, 16'h0100);
    check("R5 write one clears", {31'b0, sci}, 0);
    rd(BASE + 16'h00, d); check("R5 status after clear", d, 0);
    wr(BASE + 16'h02, 16'hFFFE);
    pulse_evt(16'h0002, 8'h00);
    check("R6 non-source bit", {31'b0, sci}, 0);
    pulse_evt(16'h0020, 8'h00);
    check("R6 global lock", {31'b0, sci}, 1);
    wr(BASE + 16'h00, 16'h0022);
    check("R6 global lock cleared", {31'b0, sci}, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = BASE; req_wdata = 16'h0400; evt_set = 16'h0400;
    @(negedge clk);
    req_valid = 0; req_write = 0; evt_set = '0;
    check("R6 rtc alarm, R5 set beats clear", {31'b0, sci}, 1);
    rd(BASE + 16'h00, d); check("R5 status set wins", d, 32'h0400);
    wr(BASE + 16'h00, 16'h0400);
    wr(BASE + 16'h02, 16'h0000);
  endtask

  task automatic t_gpe();
    logic [31:0] d;
    pulse_evt(16'h0000, 8'h02);
    check("R7 hotplug masked", {31'b0, sci}, 0);
    wr(BASE + 16'h0E, 16'h0002);
    check("R7 hotplug", {31'b0, sci}, 1);
    wr(BASE + 16'h0C, 16'h0002);
    check("R7 hotplug cleared", {31'b0, sci}, 0);
    wr(BASE + 16'h0E, 16'h00FF);
    pulse_evt(16'h0000, 8'h08);
    check("R7 other gpe bit", {31'b0, sci}, 0);
    rd(BASE + 16'h0C, d); check("R7 gpe status", d, 32'h08);
    wr(BASE + 16'h0C, 16'h00FF);
    wr(BASE + 16'h0E, 16'h0000);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    send_cmd(8'hF1);
    check("R9 smi off", {31'b0, smi}, 0);
    rd(BASE + 16'h04, d); check("R8 sci enable set", d, 1);
    send_cmd(8'h55);
    rd(BASE + 16'h04, d); check("R8 other byte", d, 1);
    send_cmd(8'hF0);
    rd(BASE + 16'h04, d); check("R8 sci enable clear", d, 0);
    cfg_smi_en = 1;
    send_cmd(8'h12);
    check("R9 smi pulse", {31'b0, smi}, 1);
    @(negedge clk);
    check("R9 smi one cycle", {31'b0, smi}, 0);
    cfg_smi_en = 0;
  endtask

  task automatic t_timer();
    logic [31:0] a, b;
    rd(BASE + 16'h08, a);
    rd(BASE + 16'h08, b);
    check("R10 step of two", (b - a) & 32'hFF, 2);
    check("R10 zero extend", b >> 8, 0);
    wr(BASE + 16'h00, 16'h0001);
    repeat (300) @(negedge clk);
    rd(BASE + 16'h00, a); check("R11 no report while disabled", a, 0);
    wr(BASE + 16'h02, 16'h0001);
    repeat (300) @(negedge clk);
    check("R11 overflow raises sci", {31'b0, sci}, 1);
    rd(BASE + 16'h00, a); check("R11 timer status", a, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_window();
        t_status_sci();
        t_gpe();
        t_cmd();
        t_timer();
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule